// File: doc/BRIEF.md
# Fault Delay Up/Down Timer

This block turns a set of already-digitised supervision flags into one delayed fault output. A reversible counter, clocked by a slow oscillator (a few kHz up to about 24 kHz), climbs while any fault is present and descends once the system is healthy again. An output latch is set when the count hits its terminal value and cleared when it returns to zero. Both directions take the same number of clock cycles, so the output has equal assertion and release delays. The delay in real time scales with the oscillator. The default terminal count of 4000 gives about 400 ms at 10 kHz.

Three fault flags feed the counter: regulator overvoltage, regulator undervoltage and watchdog failure. The watchdog also supplies a "healthy" qualifier, and only that qualifier lets the count fall. When the ignition input is absent, the block goes to standby: it ignores every monitor flag and counts down, so the output drops after the delay. A supply-good input overrides everything else. While it is low, the output is forced low at once and the counter and latch are held cleared. A free-running divide-by-four copy of the oscillator is provided as a test clock.

Top module: `fault_delay_timer`

## Requirements
- R1: After reset, fault_out is 0 and the count is 0, so a fault needs the full TERM_COUNT cycles before fault_out rises.
- R2: While sup_ok=1 and ign_on=1, each clock edge with at least one of over_v, under_v or wd_bad at 1 raises the count by one. fault_out goes to 1 at the edge where the count reaches TERM_COUNT.
- R3: While sup_ok=1 and ign_on=1, with no fault flag and wd_good=1, each edge lowers the count by one. fault_out goes to 0 at the edge where the count reaches 0.
- R4: While sup_ok=1 and ign_on=1, with no fault flag and wd_good=0, the count and fault_out hold their values.
- R5: The count saturates at TERM_COUNT. However long a fault lasts, release then takes exactly TERM_COUNT cycles.
- R6: The count saturates at 0. However long the healthy state lasts, a new fault then takes exactly TERM_COUNT cycles to set fault_out.
- R7: With sup_ok=1 and ign_on=0, the count decreases on every edge whatever the fault flags and wd_good are. fault_out falls when the count reaches 0.
- R8: While sup_ok=0, fault_out is 0 without waiting for a clock edge, and the count and latch are cleared. Once sup_ok returns, a fault needs the full TERM_COUNT cycles.
- R9: Between count limits, fault_out keeps its last value: it stays 1 on the way down and 0 on the way up until the opposite limit is reached.
- R10: test_clk is the clock divided by four, with a 50% duty cycle: it changes level every second clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_ok | input | 1 | Supply-good flag; low freezes and clears the timer |
| ign_on | input | 1 | Ignition present; low selects standby |
| over_v | input | 1 | Regulator overvoltage fault |
| under_v | input | 1 | Regulator undervoltage fault |
| wd_bad | input | 1 | Watchdog failure fault |
| wd_good | input | 1 | Watchdog healthy qualifier, needed to count down |
| fault_out | output | 1 | Delayed fault output |
| test_clk | output | 1 | Clock divided by four |

## Verification
Directed runs apply each fault flag alone from a zero count. This shows that every flag drives the count upward, and that the rise comes exactly TERM_COUNT cycles later rather than one cycle early or late. Long faults and long healthy stretches followed by a change of direction separate correct saturation from wrap-around. Partial swings, where a fault is reversed half-way, separate a latch that holds between the limits from plain threshold decoding. Random segments mix ignition loss, dropped wd_good and supply loss against a bench model, which exposes wrong priority between standby, hold and supply clearing.

// File: rtl/fdt_pkg.sv
package fdt_pkg;

    // Count direction chosen each cycle
    typedef enum logic [1:0] {
        DIR_HOLD  = 2'd0,
        DIR_UP    = 2'd1,
        DIR_DOWN  = 2'd2,
        DIR_CLEAR = 2'd3
    } dir_e;

    // Grouped fault flags
    typedef struct packed {
        logic over_v;
        logic under_v;
        logic wd_bad;
    } fault_vec_t;

endpackage

// File: rtl/fdt_direction.sv
module fdt_direction
    import fdt_pkg::*;
(
    input  logic       sup_ok,
    input  logic       ign_on,
    input  fault_vec_t faults,
    input  logic       wd_good,
    output dir_e       dir
);

    logic any_fault;

    always_comb begin
        any_fault = |faults;
        if (!sup_ok) begin
            dir = DIR_CLEAR;
        end else if (!ign_on) begin
            // standby: monitor inputs ignored
            dir = DIR_DOWN;
        end else if (any_fault) begin
            dir = DIR_UP;
        end else if (wd_good) begin
            dir = DIR_DOWN;
        end else begin
            dir = DIR_HOLD;
        end
    end

endmodule

// File: rtl/fdt_counter.sv
module fdt_counter
    import fdt_pkg::*;
#(
    parameter int TERM_COUNT = 4000,
    localparam int CNT_W = $clog2(TERM_COUNT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dir_e             dir,
    output logic [CNT_W-1:0] cnt_q,
    output logic             top_d,
    output logic             zero_d
);

    localparam logic [CNT_W-1:0] TOP_V  = CNT_W'(TERM_COUNT);
    localparam logic [CNT_W-1:0] ZERO_V = '0;
    localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (dir)
            DIR_UP:    if (st_q.cnt != TOP_V)  st_d.cnt = st_q.cnt + ONE_V;
            DIR_DOWN:  if (st_q.cnt != ZERO_V) st_d.cnt = st_q.cnt - ONE_V;
            DIR_CLEAR: st_d.cnt = ZERO_V;
            default:   st_d.cnt = st_q.cnt;
        endcase
        top_d  = (st_d.cnt == TOP_V);
        zero_d = (st_d.cnt == ZERO_V);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q = st_q.cnt;

endmodule

// File: rtl/fdt_out_latch.sv
module fdt_out_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic set_i,
    input  logic reset_i,
    output logic q
);

    typedef struct packed {
        logic on;
    } lat_state_t;

    lat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear)        st_d.on = 1'b0;
        else if (set_i)   st_d.on = 1'b1;
        else if (reset_i) st_d.on = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.on;

endmodule

// File: rtl/fdt_clk_div.sv
module fdt_clk_div #(
    parameter int DIV_LOG2 = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic div_clk
);

    generate
        if (DIV_LOG2 <= 1) begin : g_toggle
            typedef struct packed { logic t; } tog_t;
            tog_t st_d, st_q;
            always_comb st_d.t = ~st_q.t;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end
            assign div_clk = st_q.t;
        end else begin : g_count
            typedef struct packed { logic [DIV_LOG2-1:0] c; } div_t;
            div_t st_d, st_q;
            always_comb st_d.c = st_q.c + DIV_LOG2'(1);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end
            assign div_clk = st_q.c[DIV_LOG2-1];
        end
    endgenerate

endmodule

// File: rtl/fault_delay_timer.sv
module fault_delay_timer
    import fdt_pkg::*;
#(
    parameter int TERM_COUNT = 4000,
    parameter int DIV_LOG2   = 2,
    localparam int CNT_W = $clog2(TERM_COUNT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_ok,
    input  logic ign_on,
    input  logic over_v,
    input  logic under_v,
    input  logic wd_bad,
    input  logic wd_good,
    output logic fault_out,
    output logic test_clk
);

    fault_vec_t       faults;
    dir_e             dir;
    logic [CNT_W-1:0] cnt_q;
    logic             top_d;
    logic             zero_d;
    logic             lat_q;

    assign faults = '{over_v: over_v, under_v: under_v, wd_bad: wd_bad};

    fdt_direction u_dir (
        .sup_ok  (sup_ok),
        .ign_on  (ign_on),
        .faults  (faults),
        .wd_good (wd_good),
        .dir     (dir)
    );

    fdt_counter #(.TERM_COUNT(TERM_COUNT)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .dir    (dir),
        .cnt_q  (cnt_q),
        .top_d  (top_d),
        .zero_d (zero_d)
    );

    fdt_out_latch u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (dir == DIR_CLEAR),
        .set_i   (top_d),
        .reset_i (zero_d),
        .q       (lat_q)
    );

    fdt_clk_div #(.DIV_LOG2(DIV_LOG2)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_clk (test_clk)
    );

    // supply loss gates the output without waiting for a clock
    assign fault_out = lat_q & sup_ok;

endmodule

// File: rtl/fault_delay_timer_chk.sv
module fault_delay_timer_chk #(
    parameter int TERM_COUNT = 4000,
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sup_ok,
    input logic             ign_on,
    input logic             over_v,
    input logic             under_v,
    input logic             wd_bad,
    input logic             wd_good,
    input logic             fault_out,
    input logic [CNT_W-1:0] cnt,
    input logic             lat
);

    localparam logic [CNT_W-1:0] TOP_V = CNT_W'(TERM_COUNT);

    logic flt;
    assign flt = over_v | under_v | wd_bad;

    // R8
    sup_low_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_ok |-> !fault_out);

    // R8
    sup_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_ok |=> (cnt == '0) && !lat);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP_V);

    // R2
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_ok && ign_on && flt && cnt != TOP_V) |=> cnt == $past(cnt) + 1'b1);

    // R7
    standby_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_ok && !ign_on && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_ok && ign_on && !flt && !wd_good) |=> $stable(cnt) && $stable(lat));

    // R2
    top_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == TOP_V) |-> lat);

    // R3
    zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> !lat);

endmodule

bind fault_delay_timer fault_delay_timer_chk #(
    .TERM_COUNT (TERM_COUNT),
    .CNT_W      (CNT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sup_ok    (sup_ok),
    .ign_on    (ign_on),
    .over_v    (over_v),
    .under_v   (under_v),
    .wd_bad    (wd_bad),
    .wd_good   (wd_good),
    .fault_out (fault_out),
    .cnt       (cnt_q),
    .lat       (lat_q)
);

// File: tb/fault_delay_timer_tb.sv
`timescale 1ns/1ps
module fault_delay_timer_tb_top;

    localparam int TC = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sup_ok = 1'b1, ign_on = 1'b1;
    logic over_v = 1'b0, under_v = 1'b0, wd_bad = 1'b0, wd_good = 1'b1;
    logic fault_out, test_clk;

    int n_chk = 0;
    int n_fail = 0;
    int m_cnt = 0;
    bit m_lat = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fault_delay_timer #(.TERM_COUNT(TC), .DIV_LOG2(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .sup_ok(sup_ok), .ign_on(ign_on),
        .over_v(over_v), .under_v(under_v), .wd_bad(wd_bad), .wd_good(wd_good),
        .fault_out(fault_out), .test_clk(test_clk)
    );

    function automatic int next_cnt(int c, bit s, bit ig, bit f, bit g);
        if (!s)      return 0;
        if (!ig)     return (c > 0) ? c - 1 : 0;
        if (f)       return (c < TC) ? c + 1 : TC;
        if (g)       return (c > 0) ? c - 1 : 0;
        return c;
    endfunction

    function automatic bit next_lat(bit l, int c_new, bit s);
        if (!s)        return 1'b0;
        if (c_new == TC) return 1'b1;
        if (c_new == 0)  return 1'b0;
        return l;
    endfunction

    task automatic check(string tag, bit act, bit exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: fault_out=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: model follows the edge, output sampled at the falling edge
    task automatic tick(string tag);
        @(posedge clk);
        m_cnt = next_cnt(m_cnt, sup_ok, ign_on, over_v | under_v | wd_bad, wd_good);
        m_lat = next_lat(m_lat, m_cnt, sup_ok);
        @(negedge clk);
        check(tag, fault_out, m_lat & sup_ok);
    endtask

    task automatic set_in(bit s, bit ig, bit ov, bit uv, bit wb, bit wg);
        sup_ok = s; ign_on = ig; over_v = ov; under_v = uv; wd_bad = wb; wd_good = wg;
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    // R10: divide-by-four clock, level changes every second edge
    bit tc_h0, tc_h1;
    int tc_seen = 0;
    always @(negedge clk) begin
        if (!rst_n) tc_seen = 0;
        else begin
            if (tc_seen >= 2) begin
                n_chk++;
                if (test_clk === tc_h1) begin
                    n_fail++;
                    $display("FAIL R10: test_clk=%0b expected %0b", test_clk, ~tc_h1);
                end
            end
            tc_h1 = tc_h0;
            tc_h0 = test_clk;
            tc_seen++;
        end
    end

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1
        check("R1", fault_out, 1'b0);

        // R2: each flag alone, exact rise
        set_in(1, 1, 1, 0, 0, 1);
        run(TC - 1, "R2 early");
        check("R2 still low", fault_out, 1'b0);
        tick("R2 rise");
        check("R2 high", fault_out, 1'b1);
        // R5: long fault then release
        run(15, "R5 sat");
        set_in(1, 1, 0, 0, 0, 1);
        run(TC - 1, "R3 R9 hold high");
        check("R3 still high", fault_out, 1'b1);
        tick("R3 fall");
        check("R3 low", fault_out, 1'b0);
        // R6: long healthy then under_v
        run(12, "R6 sat");
        set_in(1, 1, 0, 1, 0, 1);
        run(TC, "R6 under");
        check("R6 high", fault_out, 1'b1);
        // R4: no fault, no good -> hold
        set_in(1, 1, 0, 0, 0, 0);
        run(30, "R4 hold");
        check("R4 held", fault_out, 1'b1);
        // R9: partial down then back up stays high
        set_in(1, 1, 0, 0, 0, 1);
        run(TC / 2, "R9 down");
        set_in(1, 1, 0, 0, 1, 0);
        run(TC / 2, "R9 up");
        check("R9 high", fault_out, 1'b1);
        // R7: ignition off ignores faults
        set_in(1, 0, 1, 1, 1, 0);
        run(TC - 1, "R7 down");
        check("R7 still high", fault_out, 1'b1);
        tick("R7 fall");
        check("R7 low", fault_out, 1'b0);
        // R8: supply loss immediate
        set_in(1, 1, 0, 0, 1, 0);
        run(TC + 2, "R8 prep");
        sup_ok = 1'b0;
        #1;
        check("R8 immediate", fault_out, 1'b0);
        run(3, "R8 off");
        sup_ok = 1'b1;
        run(TC - 1, "R8 restart");
        check("R8 restart low", fault_out, 1'b0);
        tick("R8 rise");
        check("R8 high", fault_out, 1'b1);

        // random segments against the model
        for (int s = 0; s < 400; s++) begin
            int len;
            bit f;
            len = 1 + int'($urandom_range(0, 40));
            f = ($urandom_range(0, 1) == 1);
            set_in($urandom_range(0, 15) != 0, $urandom_range(0, 7) != 0,
                   f & ($urandom_range(0, 2) == 0), f & ($urandom_range(0, 2) == 1),
                   f & ($urandom_range(0, 2) == 2), $urandom_range(0, 3) != 0);
            run(len, "R2/R3/R4/R7/R8 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule